// File: doc/BRIEF.md
# Coincidence-Driven Bounded Weight Updater

This block keeps a bank of unsigned fixed-point synaptic weights for a spiking crossbar of `ROWS` input rows and `COLS` output columns. When one or more columns fire a postsynaptic spike, the block captures the presynaptic pulses and their signs present in that cycle. It then walks through every spiking column one row per clock. Each weight whose row carried a pulse is moved toward its bound. A positive pulse raises the weight by a fraction `rate_p` of its remaining headroom `W_MAX - w`. A negative pulse lowers the weight by a fraction `rate_d` of its present value.

Both rates are unsigned Q0.16 fractions and the products are truncated. Because each step is proportional to the distance left to the bound, repeated pulses in one direction give shrinking changes, and the weight levels off at the bound. A one-cycle-latency read port returns any weight by row and column. The `init_load_i` input writes a programmable starting value into the whole bank.

Top module: `syn_update_unit`

## Requirements
- R1: After the asynchronous reset every weight reads 0 and `busy_o` is low. A cycle with `init_load_i` high loads every weight with `min(init_w_i, W_MAX)`, cancels any job in progress, and leaves `busy_o` low on the next cycle.
- R2: `rd_data_o` shows the weight at (`rd_row_i`, `rd_col_i`) as sampled at the previous rising clock edge.
- R3: A weight changes only if its column was spiking and its row had `pre_valid_i` set in the accepting cycle. All other weights keep their values.
- R4: With `pre_pol_i`=1 the weight becomes `w + floor(rate_p*(W_MAX-w)/65536)`.
- R5: With `pre_pol_i`=0 the weight becomes `w - floor(rate_d*w/65536)`.
- R6: The potentiation rate has no effect on depression, and the depression rate has no effect on potentiation.
- R7: Weights never leave [0, `W_MAX`]. A step that rounds to zero leaves the weight bit-exact.
- R8: A spike is accepted in any cycle in which the block is idle and `init_load_i` is low. `busy_o` is then high for exactly `ROWS` times the number of spiking columns, starting in the cycle after acceptance. Columns are processed in ascending index order.
- R9: Spikes, pulses and rate values presented while `busy_o` is high are ignored. The rates and pulses used for a job are the ones captured at acceptance.
- R10: Repeated potentiation of one weight at a fixed rate gives steps that never grow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_load_i | input | 1 | Load the whole bank from init_w_i |
| init_w_i | input | W_W | Initial weight value |
| rate_p_i | input | 16 | Potentiation rate, Q0.16 |
| rate_d_i | input | 16 | Depression rate, Q0.16 |
| pre_valid_i | input | ROWS | Presynaptic pulse per row |
| pre_pol_i | input | ROWS | Pulse sign per row, 1 = positive |
| post_spike_i | input | COLS | Postsynaptic spike strobe per column |
| busy_o | output | 1 | Update job in progress |
| rd_row_i | input | $clog2(ROWS) | Read row index |
| rd_col_i | input | $clog2(COLS) | Read column index |
| rd_data_o | output | W_W | Registered read data |

## Verification
A job accepted at clock edge E0 writes row r of the k-th spiking column at edge E0+k*ROWS+r+1. `busy_o` first reads high just after E0 and falls at edge E0+ROWS*k. The bench counts negative edges from the acceptance and checks `busy_o` on each one. It reads weights only after the busy flag has dropped. A read address set at a negative edge is sampled at the next rising edge, and the data is checked at the negative edge after that. This matches the single register in the read path.

// File: rtl/syn_pkg.sv
package syn_pkg;
  localparam int RATE_W = 16;
  typedef logic [RATE_W-1:0] rate_t;
  typedef enum logic {POL_NEG = 1'b0, POL_POS = 1'b1} pol_e;
endpackage

// File: rtl/syn_step_calc.sv
module syn_step_calc
  import syn_pkg::*;
#(
  parameter int W_W   = 12,
  parameter int W_MAX = 4000
) (
  input  logic [W_W-1:0] w_i,
  input  logic           pol_i,
  input  rate_t          rate_p_i,
  input  rate_t          rate_d_i,
  output logic [W_W-1:0] w_o
);
  localparam int PW = W_W + RATE_W;
  localparam logic [W_W:0] MAXV = (W_W+1)'(W_MAX);

  logic [W_W:0]   head;
  logic [PW-1:0]  prod_p, prod_d;
  logic [W_W-1:0] step_p, step_d;
  logic [W_W:0]   sum_p;

  always_comb begin
    head   = ({1'b0, w_i} >= MAXV) ? '0 : (MAXV - {1'b0, w_i});
    prod_p = PW'(rate_p_i) * PW'(head[W_W-1:0]);
    prod_d = PW'(rate_d_i) * PW'(w_i);
    step_p = prod_p[PW-1:RATE_W];
    step_d = prod_d[PW-1:RATE_W];
    sum_p  = {1'b0, w_i} + {1'b0, step_p};
    if (pol_e'(pol_i) == POL_POS) begin
      w_o = (sum_p > MAXV) ? MAXV[W_W-1:0] : sum_p[W_W-1:0];
    end else begin
      w_o = (step_d > w_i) ? '0 : (w_i - step_d);
    end
  end
endmodule

// File: rtl/syn_weight_bank.sv
module syn_weight_bank #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int W_W   = 12,
  parameter int W_MAX = 4000,
  localparam int N    = ROWS * COLS,
  localparam int IW   = $clog2(N)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           init_load_i,
  input  logic [W_W-1:0] init_w_i,
  input  logic [IW-1:0]  upd_idx_i,
  output logic [W_W-1:0] upd_w_o,
  input  logic           wr_en_i,
  input  logic [W_W-1:0] wr_data_i,
  input  logic [IW-1:0]  rd_idx_i,
  output logic [W_W-1:0] rd_data_o
);
  logic [W_W-1:0] mem [N];
  logic [W_W-1:0] init_clamped;

  assign init_clamped = (init_w_i > W_W'(W_MAX)) ? W_W'(W_MAX) : init_w_i;
  assign upd_w_o      = mem[upd_idx_i];

  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem[i] <= '0;
      else if (init_load_i)                         mem[i] <= init_clamped;
      else if (wr_en_i && upd_idx_i == IW'(i))      mem[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= mem[rd_idx_i];
  end
endmodule

// File: rtl/syn_col_sequencer.sv
module syn_col_sequencer
  import syn_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            init_load_i,
  input  logic [ROWS-1:0] pre_valid_i,
  input  logic [ROWS-1:0] pre_pol_i,
  input  logic [COLS-1:0] post_spike_i,
  input  rate_t           rate_p_i,
  input  rate_t           rate_d_i,
  output logic            busy_o,
  output logic [RW-1:0]   row_o,
  output logic [CW-1:0]   col_o,
  output logic            wr_en_o,
  output logic            pol_o,
  output rate_t           rate_p_o,
  output rate_t           rate_d_o
);
  logic            busy_q;
  logic [RW-1:0]   row_q;
  logic [CW-1:0]   col_q;
  logic [COLS-1:0] mask_q, mask_rest;
  logic [ROWS-1:0] pre_q, pol_q;
  rate_t           rp_q, rd_q;
  logic [CW-1:0]   first_new, first_rest;
  logic            any_rest;

  // lowest set column of a new spike and of the remaining mask
  always_comb begin
    first_new  = '0;
    for (int c = COLS - 1; c >= 0; c--) if (post_spike_i[c]) first_new = CW'(c);
    mask_rest  = mask_q & ~(COLS'(1) << col_q);
    first_rest = '0;
    for (int c = COLS - 1; c >= 0; c--) if (mask_rest[c]) first_rest = CW'(c);
    any_rest   = |mask_rest;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      mask_q <= '0;
      pre_q  <= '0;
      pol_q  <= '0;
      rp_q   <= '0;
      rd_q   <= '0;
    end else if (init_load_i) begin
      busy_q <= 1'b0;
      mask_q <= '0;
    end else if (!busy_q) begin
      if (|post_spike_i) begin
        busy_q <= 1'b1;
        mask_q <= post_spike_i;
        col_q  <= first_new;
        row_q  <= '0;
        pre_q  <= pre_valid_i;
        pol_q  <= pre_pol_i;
        rp_q   <= rate_p_i;
        rd_q   <= rate_d_i;
      end
    end else if (row_q == RW'(ROWS - 1)) begin
      row_q  <= '0;
      mask_q <= mask_rest;
      col_q  <= first_rest;
      busy_q <= any_rest;
    end else begin
      row_q <= row_q + 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign row_o    = row_q;
  assign col_o    = col_q;
  assign wr_en_o  = busy_q && pre_q[row_q];
  assign pol_o    = pol_q[row_q];
  assign rate_p_o = rp_q;
  assign rate_d_o = rd_q;
endmodule

// File: rtl/syn_update_unit.sv
module syn_update_unit
  import syn_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int W_W   = 12,
  parameter int W_MAX = 4000,
  localparam int RW   = $clog2(ROWS),
  localparam int CW   = $clog2(COLS),
  localparam int IW   = $clog2(ROWS * COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_load_i,
  input  logic [W_W-1:0]    init_w_i,
  input  logic [RATE_W-1:0] rate_p_i,
  input  logic [RATE_W-1:0] rate_d_i,
  input  logic [ROWS-1:0]   pre_valid_i,
  input  logic [ROWS-1:0]   pre_pol_i,
  input  logic [COLS-1:0]   post_spike_i,
  output logic              busy_o,
  input  logic [RW-1:0]     rd_row_i,
  input  logic [CW-1:0]     rd_col_i,
  output logic [W_W-1:0]    rd_data_o
);
  logic [RW-1:0]  row;
  logic [CW-1:0]  col;
  logic           wr_en, pol;
  rate_t          rp, rd;
  logic [W_W-1:0] cur_w, wr_data;
  logic [IW-1:0]  upd_idx, rd_idx;

  assign upd_idx = IW'(col) * IW'(ROWS) + IW'(row);
  assign rd_idx  = IW'(rd_col_i) * IW'(ROWS) + IW'(rd_row_i);

  syn_col_sequencer #(.ROWS(ROWS), .COLS(COLS)) u_seq (
    .clk_i, .rst_ni, .init_load_i, .pre_valid_i, .pre_pol_i, .post_spike_i,
    .rate_p_i, .rate_d_i, .busy_o, .row_o(row), .col_o(col), .wr_en_o(wr_en),
    .pol_o(pol), .rate_p_o(rp), .rate_d_o(rd)
  );

  syn_step_calc #(.W_W(W_W), .W_MAX(W_MAX)) u_calc (
    .w_i(cur_w), .pol_i(pol), .rate_p_i(rp), .rate_d_i(rd), .w_o(wr_data)
  );

  syn_weight_bank #(.ROWS(ROWS), .COLS(COLS), .W_W(W_W), .W_MAX(W_MAX)) u_bank (
    .clk_i, .rst_ni, .init_load_i, .init_w_i, .upd_idx_i(upd_idx),
    .upd_w_o(cur_w), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o
  );
endmodule

// File: rtl/syn_update_unit_chk.sv
module syn_update_unit_chk #(
  parameter int COLS  = 4,
  parameter int W_W   = 12,
  parameter int W_MAX = 4000
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            init_load_i,
  input logic [COLS-1:0] post_spike_i,
  input logic            busy_o,
  input logic            wr_en,
  input logic [W_W-1:0]  wr_data,
  input logic [W_W-1:0]  rd_data_o
);
  a_r8_busy_needs_spike: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(|post_spike_i));
  a_r9_idle_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(|post_spike_i)) |=> !busy_o);
  a_r1_init_clears_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_load_i |=> !busy_o);
  a_r3_write_in_job: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> busy_o);
  a_r7_write_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (wr_data <= W_W'(W_MAX)));
  a_r7_read_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o <= W_W'(W_MAX));
endmodule

bind syn_update_unit syn_update_unit_chk #(.COLS(COLS), .W_W(W_W), .W_MAX(W_MAX)) u_chk (
  .clk_i, .rst_ni, .init_load_i, .post_spike_i, .busy_o,
  .wr_en, .wr_data, .rd_data_o
);

// File: tb/syn_update_unit_tb.sv
module syn_update_unit_tb;
  localparam int ROWS = 4, COLS = 4, W_W = 12, W_MAX = 4000;

  logic clk = 0, rst_n = 0;
  logic init_load = 0;
  logic [W_W-1:0] init_w = '0;
  logic [15:0] rate_p = '0, rate_d = '0;
  logic [ROWS-1:0] pre_v = '0, pre_p = '0;
  logic [COLS-1:0] spike = '0;
  logic busy;
  logic [1:0] rd_row = '0, rd_col = '0;
  logic [W_W-1:0] rd_data;

  int exp_w [ROWS][COLS];
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  syn_update_unit #(.ROWS(ROWS), .COLS(COLS), .W_W(W_W), .W_MAX(W_MAX)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .init_load_i(init_load), .init_w_i(init_w),
    .rate_p_i(rate_p), .rate_d_i(rate_d), .pre_valid_i(pre_v), .pre_pol_i(pre_p),
    .post_spike_i(spike), .busy_o(busy), .rd_row_i(rd_row), .rd_col_i(rd_col),
    .rd_data_o(rd_data)
  );

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int pot(input int w, input int rp);
    int v = w + int'((longint'(rp) * longint'(W_MAX - w)) >>> 16);
    return (v > W_MAX) ? W_MAX : v;
  endfunction

  function automatic int dep(input int w, input int rd);
    return w - int'((longint'(rd) * longint'(w)) >>> 16);
  endfunction

  task automatic read_w(input int r, input int c, output int v);
    @(negedge clk);
    rd_row = 2'(r); rd_col = 2'(c);
    @(posedge clk);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic check_bank(input string req);
    int v;
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) begin
        read_w(r, c, v);
        chk(v == exp_w[r][c], req, v, exp_w[r][c]);
      end
  endtask

  task automatic do_init(input int val);
    @(negedge clk);
    init_w = W_W'(val); init_load = 1;
    @(negedge clk);
    init_load = 0;
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) exp_w[r][c] = (val > W_MAX) ? W_MAX : val;
  endtask

  // accept a job, check busy window (R8), update the model
  task automatic do_job(input logic [ROWS-1:0] v, input logic [ROWS-1:0] p,
                        input logic [COLS-1:0] s, input int rp, input int rd);
    int k = $countones(s);
    int hi = 0;
    @(negedge clk);
    pre_v = v; pre_p = p; spike = s; rate_p = 16'(rp); rate_d = 16'(rd);
    @(posedge clk);
    for (int i = 0; i < ROWS * k; i++) begin
      @(negedge clk);
      spike = '0; pre_v = '0;
      if (busy) hi++;
    end
    chk(hi == ROWS * k, "R8 busy length", hi, ROWS * k);
    @(negedge clk);
    chk(busy == 1'b0, "R8 busy falls", int'(busy), 0);
    for (int c = 0; c < COLS; c++)
      if (s[c])
        for (int r = 0; r < ROWS; r++)
          if (v[r]) exp_w[r][c] = p[r] ? pot(exp_w[r][c], rp) : dep(exp_w[r][c], rd);
  endtask

  task automatic t_reset;
    int v;
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    for (int c = 0; c < COLS; c++) for (int r = 0; r < ROWS; r++) exp_w[r][c] = 0;
    check_bank("R1 reset weights");
    read_w(1, 2, v);
    chk(v == 0, "R2 read after reset", v, 0);
  endtask

  task automatic t_init;
    int v;
    do_init(1000);
    check_bank("R1 init load");
    do_init(4095);
    read_w(3, 3, v);
    chk(v == W_MAX, "R1 R7 init clamp", v, W_MAX);
  endtask

  task automatic t_read_latency;
    do_init(1000);
    do_job(4'b0001, 4'b0001, 4'b0100, 16'h4000, 0);
    @(negedge clk);
    rd_row = 0; rd_col = 0;
    @(posedge clk);
    @(negedge clk);
    rd_row = 0; rd_col = 2;
    chk(int'(rd_data) == 1000, "R2 latency old addr", int'(rd_data), 1000);
    @(posedge clk);
    @(negedge clk);
    chk(int'(rd_data) == 1750, "R2 latency new addr", int'(rd_data), 1750);
  endtask

  task automatic t_single_col;
    do_init(1000);
    do_job(4'b0111, 4'b0101, 4'b0010, 16'h4000, 16'h8000);
    chk(exp_w[0][1] == 1750, "R4 model pot", exp_w[0][1], 1750);
    chk(exp_w[1][1] == 500, "R5 model dep", exp_w[1][1], 500);
    check_bank("R3 R4 R5 single column");
  endtask

  task automatic t_multi_col;
    int v1, v2, v3, s1, s2;
    do_init(0);
    do_job(4'b1001, 4'b1001, 4'b1001, 16'h2000, 0);
    read_w(0, 0, v1);
    do_job(4'b1001, 4'b1001, 4'b1001, 16'h2000, 0);
    read_w(0, 0, v2);
    do_job(4'b1001, 4'b1001, 4'b1001, 16'h2000, 0);
    read_w(0, 0, v3);
    s1 = v2 - v1; s2 = v3 - v2;
    chk(s2 <= s1 && s2 > 0, "R10 shrinking steps", s2, s1);
    check_bank("R8 R3 two columns");
  endtask

  task automatic t_rate_indep;
    do_init(2000);
    do_job(4'b0011, 4'b0001, 4'b0001, 16'h1000, 16'h2000);
    do_job(4'b0011, 4'b0001, 4'b0010, 16'hF000, 16'h2000);
    chk(exp_w[1][0] == exp_w[1][1], "R6 model dep equal", exp_w[1][1], exp_w[1][0]);
    do_job(4'b0011, 4'b0001, 4'b0100, 16'h1000, 16'hE000);
    check_bank("R6 rate independence");
  endtask

  task automatic t_busy_ignore;
    int hi = 0;
    do_init(1000);
    @(negedge clk);
    pre_v = 4'b1111; pre_p = 4'b1111; spike = 4'b0100; rate_p = 16'h4000;
    @(posedge clk);
    @(negedge clk);
    if (busy) hi++;
    pre_v = 4'b1111; pre_p = 4'b0000; spike = 4'b0001; rate_p = 16'hFFFF;
    for (int i = 1; i < ROWS; i++) begin
      @(negedge clk);
      if (busy) hi++;
    end
    spike = '0; pre_v = '0;
    @(negedge clk);
    chk(hi == ROWS && !busy, "R9 busy window unchanged", hi, ROWS);
    for (int r = 0; r < ROWS; r++) exp_w[r][2] = pot(1000, 16'h4000);
    check_bank("R9 ignored during busy");
  endtask

  task automatic t_zero_and_bound;
    do_init(4000);
    do_job(4'b1111, 4'b1111, 4'b1000, 16'hFFFF, 0);
    do_init(3);
    do_job(4'b1111, 4'b0000, 4'b0001, 0, 16'h4000);
    do_job(4'b0011, 4'b0011, 4'b0010, 0, 0);
    chk(exp_w[0][0] == 3, "R7 model zero step", exp_w[0][0], 3);
    check_bank("R7 zero step and bound");
    do_init(500);
    do_job(4'b1111, 4'b0000, 4'b0001, 0, 16'hFFFF);
    check_bank("R5 R7 full depression");
  endtask

  task automatic t_init_abort;
    int v;
    do_init(1000);
    @(negedge clk);
    pre_v = 4'b1111; pre_p = 4'b1111; spike = 4'b1111; rate_p = 16'h8000;
    @(posedge clk);
    @(negedge clk);
    spike = '0; pre_v = '0;
    init_w = 12'd700; init_load = 1;
    @(negedge clk);
    init_load = 0;
    chk(busy == 1'b0, "R1 init cancels job", int'(busy), 0);
    for (int c = 0; c < COLS; c++) for (int r = 0; r < ROWS; r++) exp_w[r][c] = 700;
    repeat (4) @(negedge clk);
    read_w(3, 3, v);
    chk(v == 700, "R1 R3 no write after init", v, 700);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_init();
    t_read_latency();
    t_single_col();
    t_multi_col();
    t_rate_indep();
    t_busy_ignore();
    t_zero_and_bound();
    t_init_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule